// File: doc/BRIEF.md
# Swept Sawtooth Frequency Generator

This block is a numerically controlled sawtooth source for a resonant half-bridge inverter. A phase accumulator advances every clock by an increment that a control word selects. Control word zero gives the highest frequency. The largest control word gives the lowest frequency. The increment falls linearly between two parameter limits as the word rises, so the ratio between the highest and the lowest frequency is fixed by those limits. A wrap of the accumulator marks one sawtooth period. The sawtooth runs at twice the switching rate of the bridge, so two wraps make one bridge cycle.

After enable, the generator starts at the highest frequency. While the lamp is being struck, the control word climbs at a fixed rate and sweeps the frequency downward. When the word reaches its clamp value, the block takes this as a lit lamp. It moves to regulation, raises the minimum-frequency flag, and from then on adds a signed correction from the lamp-current loop to the control word each cycle. A hold input freezes the control word but leaves the accumulator running.

A capacitive-mode request overrides everything. The increment snaps to its maximum, and the control word is discharged by one step per cycle. Once the word is zero and the request has gone, the sweep starts again.

The mode output has four states, named as follows:
- IDLE (0): disabled.
- SWEEP (1): ignition sweep.
- REGULATE (2): burn regulation.
- CAPM (3): capacitive override.

The transitions between them are named as follows:
- start: IDLE to SWEEP when enable is high.
- lit: SWEEP to REGULATE when the control word is at its clamp.
- cap_hit: SWEEP or REGULATE to CAPM when cap_req is high.
- recover: CAPM to SWEEP when the control word is zero and cap_req is low.
- shutdown: any state to IDLE when enable is low.

Top module: `saw_sweep_gen`

## Requirements
- R1: While in reset or IDLE, the following outputs are all 0: mode, phase, ctrl_word, wrap_pulse and fmin_reached. A low enable moves any state to IDLE at the next edge. The phase output is 0 from the edge after that.
- R2: When enable is high in IDLE, the next edge gives mode SWEEP (1) with ctrl_word 0, which is the highest frequency.
- R3: Outside CAPM, each edge adds an increment to phase, modulo 2^PH_W. The increment is INC_MAX - (((INC_MAX-INC_MIN)*ctrl_word) >> CW_W), using the ctrl_word value seen before that edge.
- R4: In SWEEP with hold low, ctrl_word rises by exactly 1 every RAMP_DIV edges. It stops at the clamp value 2^CW_W-1. The rate prescaler restarts at 0 on entry to SWEEP.
- R5: When ctrl_word equals the clamp in SWEEP, the next edge gives mode REGULATE (2). fmin_reached is 1 exactly while mode is REGULATE.
- R6: In REGULATE with hold low, each edge adds the signed correction corr to ctrl_word. The result saturates at 0 and at the clamp.
- R7: hold freezes ctrl_word and the ramp prescaler in SWEEP and REGULATE. The phase keeps advancing as in R3.
- R8: cap_req high in SWEEP or REGULATE gives mode CAPM (3) at the next edge. In CAPM each edge adds INC_MAX to phase, whatever the value of ctrl_word.
- R9: In CAPM, ctrl_word falls by 1 per edge down to 0. The block returns to SWEEP at the edge where ctrl_word is 0 and cap_req is low, and it stays in CAPM while cap_req is high.
- R10: wrap_pulse is 1 for the one cycle after an edge at which the accumulator overflowed. At INC_MAX with default parameters, wrap pulses are 16 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator; low returns to IDLE |
| hold | input | 1 | Freezes the control word |
| cap_req | input | 1 | Capacitive-mode request |
| corr | input | CORR_W | Signed correction from the current loop, used in REGULATE |
| phase | output | PH_W | Sawtooth phase value |
| wrap_pulse | output | 1 | Sawtooth period boundary |
| fmin_reached | output | 1 | Minimum frequency reached (REGULATE) |
| ctrl_word | output | CW_W | Current control word |
| mode | output | 2 | State: 0 IDLE, 1 SWEEP, 2 REGULATE, 3 CAPM |

## Verification
Every result in this block is due one edge after its cause:
- a new phase value uses the increment from the mode and control word held before the edge;
- a state change follows one edge after enable, cap_req or the clamp;
- a control-word step follows one edge after its prescaler tick or correction;
- fmin_reached rises one edge after the clamp is reached, because it is decoded from the state register.

The bench drives inputs and reads outputs on falling edges only. It records the outputs before a rising edge and compares them with the outputs read at the next falling edge. Every step comparison therefore spans exactly one register stage. Timing over longer windows, such as the ramp rate and the wrap spacing, is checked by counting those single steps.

// File: rtl/sawgen_pkg.sv
package sawgen_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_SWEEP    = 2'd1,
        MODE_REGULATE = 2'd2,
        MODE_CAPM     = 2'd3
    } saw_mode_e;
endpackage

// File: rtl/sawgen_ctrl.sv
module sawgen_ctrl
    import sawgen_pkg::*;
#(
    parameter int CW_W     = 8,
    parameter int CORR_W   = 8,
    parameter int RAMP_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     hold,
    input  logic                     cap_req,
    input  logic signed [CORR_W-1:0] corr,
    output saw_mode_e                state,
    output logic [CW_W-1:0]          cw,
    output logic                     fmin
);
    localparam int PRE_W = $clog2(RAMP_DIV + 1);
    localparam logic [CW_W-1:0] CW_CLAMP = {CW_W{1'b1}};
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(RAMP_DIV - 1);
    localparam int SUM_W = ((CW_W + 1) > CORR_W ? (CW_W + 1) : CORR_W) + 1;

    saw_mode_e        state_n;
    logic [CW_W-1:0]  cw_n;
    logic [PRE_W-1:0] pre, pre_n;
    logic signed [SUM_W-1:0] reg_sum;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            MODE_IDLE:     if (enable) state_n = MODE_SWEEP;                 // start
            MODE_SWEEP:    if (cap_req) state_n = MODE_CAPM;                 // cap_hit
                           else if (cw == CW_CLAMP) state_n = MODE_REGULATE; // lit
            MODE_REGULATE: if (cap_req) state_n = MODE_CAPM;                 // cap_hit
            MODE_CAPM:     if (cw == '0 && !cap_req) state_n = MODE_SWEEP;   // recover
        endcase
        if (!enable) state_n = MODE_IDLE;                                    // shutdown
    end

    // saturating correction sum
    always_comb begin
        reg_sum = $signed({{(SUM_W-CW_W){1'b0}}, cw}) + SUM_W'(corr);
    end

    // control word and ramp prescaler
    always_comb begin
        cw_n  = cw;
        pre_n = pre;
        unique case (state)
            MODE_IDLE: begin
                cw_n  = '0;
                pre_n = '0;
            end
            MODE_SWEEP: begin
                if (!hold) begin
                    if (pre == PRE_LAST) begin
                        pre_n = '0;
                        if (cw != CW_CLAMP) cw_n = cw + 1'b1;
                    end else begin
                        pre_n = pre + 1'b1;
                    end
                end
            end
            MODE_REGULATE: begin
                if (!hold) begin
                    if (reg_sum < 0)
                        cw_n = '0;
                    else if (reg_sum > $signed({{(SUM_W-CW_W){1'b0}}, CW_CLAMP}))
                        cw_n = CW_CLAMP;
                    else
                        cw_n = reg_sum[CW_W-1:0];
                end
            end
            MODE_CAPM: begin
                pre_n = '0;
                if (cw != '0) cw_n = cw - 1'b1;
            end
        endcase
        if (!enable) begin
            cw_n  = '0;
            pre_n = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cw  <= '0;
            pre <= '0;
        end else begin
            cw  <= cw_n;
            pre <= pre_n;
        end
    end

    // outputs decoded from state
    always_comb begin
        fmin = (state == MODE_REGULATE);
    end
endmodule

// File: rtl/sawgen_incmap.sv
module sawgen_incmap #(
    parameter int CW_W    = 8,
    parameter int PH_W    = 12,
    parameter int INC_MAX = 256,
    parameter int INC_MIN = 104
) (
    input  logic [CW_W-1:0] cw,
    input  logic            force_max,
    output logic [PH_W-1:0] inc
);
    localparam int PROD_W = CW_W + PH_W;
    localparam logic [PROD_W-1:0] SPAN = PROD_W'(INC_MAX - INC_MIN);
    localparam logic [PH_W-1:0]   TOP  = PH_W'(INC_MAX);

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = SPAN * PROD_W'(cw);
        if (force_max) inc = TOP;
        else           inc = TOP - PH_W'(prod >> CW_W);
    end
endmodule

// File: rtl/sawgen_phase.sv
module sawgen_phase #(
    parameter int PH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [PH_W-1:0] inc,
    output logic [PH_W-1:0] phase,
    output logic            wrap
);
    logic [PH_W:0] sum;

    always_comb begin
        sum = {1'b0, phase} + {1'b0, inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            wrap  <= 1'b0;
        end else if (clear) begin
            phase <= '0;
            wrap  <= 1'b0;
        end else begin
            phase <= sum[PH_W-1:0];
            wrap  <= sum[PH_W];
        end
    end
endmodule

// File: rtl/saw_sweep_gen.sv
module saw_sweep_gen
    import sawgen_pkg::*;
#(
    parameter int CW_W     = 8,
    parameter int PH_W     = 12,
    parameter int CORR_W   = 8,
    parameter int RAMP_DIV = 4,
    parameter int INC_MAX  = 256,
    parameter int INC_MIN  = 104
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     hold,
    input  logic                     cap_req,
    input  logic signed [CORR_W-1:0] corr,
    output logic [PH_W-1:0]          phase,
    output logic                     wrap_pulse,
    output logic                     fmin_reached,
    output logic [CW_W-1:0]          ctrl_word,
    output logic [1:0]               mode
);
    saw_mode_e       st;
    logic [PH_W-1:0] inc;

    sawgen_ctrl #(.CW_W(CW_W), .CORR_W(CORR_W), .RAMP_DIV(RAMP_DIV)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold),
        .cap_req(cap_req), .corr(corr), .state(st), .cw(ctrl_word),
        .fmin(fmin_reached)
    );

    sawgen_incmap #(.CW_W(CW_W), .PH_W(PH_W), .INC_MAX(INC_MAX), .INC_MIN(INC_MIN)) u_map (
        .cw(ctrl_word), .force_max(st == MODE_CAPM), .inc(inc)
    );

    sawgen_phase #(.PH_W(PH_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(st == MODE_IDLE), .inc(inc),
        .phase(phase), .wrap(wrap_pulse)
    );

    assign mode = st;
endmodule

// File: rtl/saw_sweep_gen_chk.sv
module saw_sweep_gen_chk #(
    parameter int CW_W    = 8,
    parameter int PH_W    = 12,
    parameter int INC_MAX = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            hold,
    input logic [PH_W-1:0] phase,
    input logic            wrap_pulse,
    input logic            fmin_reached,
    input logic [CW_W-1:0] ctrl_word,
    input logic [1:0]      mode
);
    localparam logic [CW_W-1:0] CLAMP = {CW_W{1'b1}};

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (phase == '0)); // R1
    AST_CAPM_MAX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (phase == PH_W'($past(phase) + PH_W'(INC_MAX)))); // R8
    AST_CAPM_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && enable) |=>
        (ctrl_word == (($past(ctrl_word) == '0) ? '0 : CW_W'($past(ctrl_word) - 1'b1)))); // R9
    AST_SWEEP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && enable) |=> (ctrl_word >= $past(ctrl_word))); // R4
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && enable && (mode == 2'd1 || mode == 2'd2)) |=> $stable(ctrl_word)); // R7
    AST_FMIN_AT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmin_reached) |-> ($past(ctrl_word) == CLAMP && $past(mode) == 2'd1)); // R5
    AST_WRAP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (phase < $past(phase))); // R10
endmodule

bind saw_sweep_gen saw_sweep_gen_chk #(.CW_W(CW_W), .PH_W(PH_W), .INC_MAX(INC_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold), .phase(phase),
    .wrap_pulse(wrap_pulse), .fmin_reached(fmin_reached),
    .ctrl_word(ctrl_word), .mode(mode)
);

// File: tb/saw_sweep_gen_test.sv
module saw_sweep_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW_W = 8, PH_W = 12, CORR_W = 8, RAMP_DIV = 4;
    localparam int INC_MAX = 256, INC_MIN = 104;
    localparam int CLAMP = 255;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, hold = 1'b0, cap_req = 1'b0;
    logic signed [CORR_W-1:0] corr = '0;
    logic [PH_W-1:0] phase;
    logic wrap_pulse, fmin_reached;
    logic [CW_W-1:0] ctrl_word;
    logic [1:0] mode;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    saw_sweep_gen #(.CW_W(CW_W), .PH_W(PH_W), .CORR_W(CORR_W), .RAMP_DIV(RAMP_DIV),
                    .INC_MAX(INC_MAX), .INC_MIN(INC_MIN)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold), .cap_req(cap_req),
        .corr(corr), .phase(phase), .wrap_pulse(wrap_pulse),
        .fmin_reached(fmin_reached), .ctrl_word(ctrl_word), .mode(mode));

    function automatic int inc_of(int cw);
        return INC_MAX - (((INC_MAX - INC_MIN) * cw) >> CW_W);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one falling edge to the next, with the phase step checked (R3, R8, R10)
    task automatic advance();
        int p0, c0, m0, inc, sum;
        p0 = phase; c0 = ctrl_word; m0 = mode;
        @(negedge clk);
        if (m0 == 0) begin
            check("R1 idle phase", phase, 0);
        end else begin
            inc = (m0 == 3) ? INC_MAX : inc_of(c0);
            sum = p0 + inc;
            check(m0 == 3 ? "R8 capm step" : "R3 phase step", phase, sum % 4096);
            check("R10 wrap", wrap_pulse, sum >= 4096 ? 1 : 0);
        end
    endtask

    task automatic t_reset();
        check("R1 mode", mode, 0);
        check("R1 phase", phase, 0);
        check("R1 cw", ctrl_word, 0);
        check("R1 wrap", wrap_pulse, 0);
        check("R1 fmin", fmin_reached, 0);
    endtask

    task automatic t_start();
        enable = 1'b1;
        advance();
        check("R2 mode sweep", mode, 1);
        check("R2 cw zero", ctrl_word, 0);
        for (int i = 0; i < 30; i++) advance();
    endtask

    task automatic t_ramp();
        int c0 = ctrl_word;
        for (int i = 0; i < 40; i++) advance();
        check("R4 ramp rate", ctrl_word - c0, 40 / RAMP_DIV);
    endtask

    task automatic t_hold_sweep();
        int c0;
        hold = 1'b1;
        advance();
        c0 = ctrl_word;
        for (int i = 0; i < 20; i++) advance();
        check("R7 hold sweep", ctrl_word, c0);
        hold = 1'b0;
        advance();
        c0 = ctrl_word;
        for (int i = 0; i < 40; i++) advance();
        check("R4 ramp after hold", ctrl_word - c0, 10);
    endtask

    task automatic t_clamp();
        int guard = 0, pc = 0, pm = 0;
        while (!fmin_reached && guard < 2000) begin
            pc = ctrl_word; pm = mode;
            advance();
            guard++;
        end
        check("R5 fmin seen", fmin_reached, 1);
        check("R5 mode regulate", mode, 2);
        check("R5 cw before", pc, CLAMP);
        check("R5 mode before", pm, 1);
    endtask

    task automatic t_regulate();
        corr = -8'sd3;
        for (int i = 0; i < 10; i++) advance();
        check("R6 decrease", ctrl_word, CLAMP - 30);
        check("R5 fmin in regulate", fmin_reached, 1);
        hold = 1'b1;
        for (int i = 0; i < 5; i++) advance();
        check("R7 hold regulate", ctrl_word, CLAMP - 30);
        hold = 1'b0;
        corr = 8'sd100;
        advance();
        check("R6 saturate top", ctrl_word, CLAMP);
        corr = -8'sd128;
        for (int i = 0; i < 3; i++) advance();
        check("R6 saturate bottom", ctrl_word, 0);
        corr = 8'sd40;
        for (int i = 0; i < 7; i++) advance();
        check("R6 rise", ctrl_word, CLAMP);
        corr = '0;
    endtask

    task automatic t_capm();
        int last_wrap = -1, cyc = 0, c0;
        cap_req = 1'b1;
        advance();
        cap_req = 1'b0;
        check("R8 mode capm", mode, 3);
        check("R9 fmin low", fmin_reached, 0);
        while (mode == 3 && cyc < 400) begin
            c0 = ctrl_word;
            advance();
            cyc++;
            if (mode == 3) check("R9 discharge", ctrl_word, c0 - 1);
            if (wrap_pulse && mode == 3) begin
                if (last_wrap >= 0) check("R10 spacing", cyc - last_wrap, 16);
                last_wrap = cyc;
            end
        end
        check("R9 recover sweep", mode, 1);
        check("R9 cw zero", ctrl_word, 0);
    endtask

    task automatic t_capm_held();
        cap_req = 1'b1;
        for (int i = 0; i < 6; i++) advance();
        check("R9 held capm", mode, 3);
        check("R9 held cw", ctrl_word, 0);
        cap_req = 1'b0;
        advance();
        check("R9 release", mode, 1);
        for (int i = 0; i < 8; i++) advance();
    endtask

    task automatic t_disable();
        enable = 1'b0;
        advance();
        check("R1 mode idle", mode, 0);
        check("R1 cw cleared", ctrl_word, 0);
        advance();
        check("R1 phase cleared", phase, 0);
        check("R1 fmin cleared", fmin_reached, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_ramp();
        t_hold_sweep();
        t_clamp();
        t_regulate();
        t_capm();
        t_capm_held();
        t_disable();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule